// File: doc/BRIEF.md
# I2C Slave Bus-Hang Watchdog

This block keeps an I2C slave from holding the bus forever. It watches the SCL and SDA lines through its own two-stage synchronizers. From them it keeps a start-seen flag and a stop-seen flag. It also takes a one-cycle activity pulse from the slave protocol engine each time that engine completes an address phase or a data byte.

Each activity pulse arms a slow poll timer and restarts both the timer and its poll count. While the watchdog is armed, the timer produces a tick every `TICK_DIV` clock cycles; the default is 4 ms at 125 MHz. On a tick with the stop-seen flag set, the watchdog concludes that the slave has let go of the bus and disarms. If `POLL_LIMIT` ticks in a row (default 256, just over one second) arrive without a stop, the watchdog pulls the slave engine's enable low for `DROP_CYCLES` cycles. It then restores the enable, returns to the disarmed state and leaves a sticky timeout flag for software to clear.

Because every byte or address event re-arms it and a stop disarms it, the watchdog never fires during a transfer that is still making progress. Only a transfer that stalls for the whole timeout is cut short.

Top module: `i2c_hang_watchdog`

## Requirements
- R1: SDA falling while SCL is high (a start) sets `start_seen` and clears `stop_seen`. SDA rising while SCL is high (a stop) sets `stop_seen` and clears `start_seen`. Both lines pass through two synchronizing flops first. SDA changes while SCL is low leave both flags unchanged.
- R2: An `slv_event` pulse while `engine_en` is high sets `wd_armed` on the next cycle and restarts the prescaler and the poll count from zero.
- R3: While armed, a poll tick occurs every `TICK_DIV` cycles. A tick that finds `stop_seen` set clears `wd_armed`, and no further ticks occur until the next `slv_event`.
- R4: If `POLL_LIMIT` consecutive ticks find `stop_seen` clear, `engine_en` goes low exactly `POLL_LIMIT*TICK_DIV` cycles after the clock edge that sampled the last `slv_event`, and not one cycle earlier.
- R5: `engine_en` stays low for exactly `DROP_CYCLES` cycles and then returns high with `wd_armed` low. An `slv_event` that arrives while `engine_en` is low is ignored.
- R6: `tmo_sticky` rises together with the fall of `engine_en` on a forced reset. It stays high until a `tmo_clear` pulse, after which it reads 0 on the next cycle.
- R7: An `slv_event` sampled on the same edge as a poll tick takes priority. The poll count returns to zero, so the forced reset moves out to a full `POLL_LIMIT*TICK_DIV` cycles after that event.
- R8: While `rst_n` is low at a clock edge, the block clears the prescaler, the poll count, the armed state, both condition flags and `tmo_sticky`, and drives `engine_en` high.
- R9: `slv_event` pulses spaced less than `POLL_LIMIT*TICK_DIV` cycles apart keep the watchdog armed indefinitely without any drop of `engine_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad |
| slv_event | input | 1 | One-cycle pulse: slave engine finished a byte or address phase |
| tmo_clear | input | 1 | One-cycle pulse clearing the sticky timeout flag |
| engine_en | output | 1 | Enable to the slave engine; low during a forced reset |
| wd_armed | output | 1 | Watchdog is armed and polling |
| tmo_sticky | output | 1 | Set by a forced reset, held until cleared |
| start_seen | output | 1 | Last bus condition seen was a start |
| stop_seen | output | 1 | Last bus condition seen was a stop |

## Verification
The hardest situation to reach is a slave event that lands on exactly the edge where a poll tick is taken. The tick phase is not visible at the ports. The bench rebuilds it by counting cycles from a known event: it issues a second event precisely `TICK_DIV` edges after the first. It then checks that the forced reset shows up one full timeout after that second event and not one tick sooner. The exact length of the enable drop, and an event arriving inside it, are reached the same way by counting from the arming event.

// File: rtl/iwd_pkg.sv
// Package: shared types for the I2C bus-hang watchdog.
// Assumes: nothing beyond the standard language.
package iwd_pkg;

    // Watchdog control states.
    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_ARMED = 2'd1,
        WD_DROP  = 2'd2
    } wd_state_t;

endpackage

// File: rtl/iwd_line_sync.sv
// Module: iwd_line_sync
// Brings the raw SCL/SDA pad levels into the clock domain through two flops
// each. Keeps one more stage of history, and flags start (SDA falls, SCL high)
// and stop (SDA rises, SCL high) as one-cycle pulses.
// Assumes: the bus idles high, so all stages reset to 1 and no false
// condition appears after reset. SCL must be high in both the current and the
// previous sample for a condition to count.
module iwd_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_det,
    output logic stop_det
);

    localparam int HIST = SYNC_STAGES + 1;

    logic [HIST-1:0] scl_pipe;
    logic [HIST-1:0] sda_pipe;

    // Shift both lines through the synchronizer and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[HIST-2:0], scl_in};
            sda_pipe <= {sda_pipe[HIST-2:0], sda_in};
        end
    end

    logic scl_now, scl_prev, sda_now, sda_prev;

    // Name the last synchronized sample and the one before it.
    always_comb begin
        scl_now  = scl_pipe[SYNC_STAGES-1];
        scl_prev = scl_pipe[SYNC_STAGES];
        sda_now  = sda_pipe[SYNC_STAGES-1];
        sda_prev = sda_pipe[SYNC_STAGES];
    end

    // Decode the bus conditions from SDA edges taken while SCL is held high.
    always_comb begin
        start_det = scl_now && scl_prev &&  sda_prev && !sda_now;
        stop_det  = scl_now && scl_prev && !sda_prev &&  sda_now;
    end

endmodule

// File: rtl/iwd_cond_flags.sv
// Module: iwd_cond_flags
// Holds the start-seen and stop-seen flags. A start sets start-seen and
// clears stop-seen; a stop does the reverse. At most one is ever set.
// Assumes: start_det and stop_det are never high in the same cycle (they
// need opposite SDA edges).
module iwd_cond_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic start_det,
    input  logic stop_det,
    output logic start_seen,
    output logic stop_seen
);

    // Track the most recent bus condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_seen <= 1'b0;
            stop_seen  <= 1'b0;
        end else if (start_det) begin
            start_seen <= 1'b1;
            stop_seen  <= 1'b0;
        end else if (stop_det) begin
            start_seen <= 1'b0;
            stop_seen  <= 1'b1;
        end
    end

endmodule

// File: rtl/iwd_poll_timer.sv
// Module: iwd_poll_timer
// Prescaler that produces a one-cycle poll tick every TICK_DIV cycles while
// run is high. A restart pulse, or run low, returns the count to zero.
// Assumes: TICK_DIV >= 2.
module iwd_poll_timer #(
    parameter int TICK_DIV = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);

    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] div_cnt;

    // The tick fires on the last count of each period while running.
    always_comb begin
        tick = run && (div_cnt == DIV_LAST);
    end

    // Advance the prescaler, wrapping on a tick and clearing on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (restart || !run || tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/iwd_guard_fsm.sv
// Module: iwd_guard_fsm
// Arm / poll / drop control. A slave event arms the watchdog and zeroes the
// poll count. Each tick either disarms (stop seen) or counts one more poll.
// The POLL_LIMIT-th poll without a stop starts an enable drop of DROP_CYCLES
// cycles, after which the watchdog is idle again. A forced reset also sets
// the sticky timeout flag.
// Assumes: tick is only high while armed. Events during the drop are
// deliberately ignored.
module iwd_guard_fsm
    import iwd_pkg::*;
#(
    parameter int POLL_LIMIT  = 256,
    parameter int DROP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slv_event,
    input  logic tick,
    input  logic stop_seen,
    input  logic tmo_clear,
    output logic armed,
    output logic engine_en,
    output logic tmo_sticky
);

    localparam int POLL_W  = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
    localparam int DROP_W  = (DROP_CYCLES > 1) ? $clog2(DROP_CYCLES) : 1;
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_LIMIT - 1);
    localparam logic [DROP_W-1:0] DROP_LAST = DROP_W'(DROP_CYCLES - 1);

    wd_state_t          state;
    logic [POLL_W-1:0]  poll_cnt;
    logic [DROP_W-1:0]  drop_cnt;
    logic               fire;

    // A forced reset happens on the last allowed tick with no stop and no re-arm.
    always_comb begin
        fire = (state == WD_ARMED) && !slv_event && tick &&
               !stop_seen && (poll_cnt == POLL_LAST);
    end

    // Main state, poll count and drop length control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= WD_IDLE;
            poll_cnt <= '0;
            drop_cnt <= '0;
        end else begin
            case (state)
                WD_IDLE: begin
                    if (slv_event) begin
                        state    <= WD_ARMED;
                        poll_cnt <= '0;
                    end
                end
                WD_ARMED: begin
                    if (slv_event) begin
                        poll_cnt <= '0;
                    end else if (tick) begin
                        if (stop_seen) begin
                            state <= WD_IDLE;
                        end else if (poll_cnt == POLL_LAST) begin
                            state    <= WD_DROP;
                            drop_cnt <= '0;
                        end else begin
                            poll_cnt <= poll_cnt + 1'b1;
                        end
                    end
                end
                WD_DROP: begin
                    if (drop_cnt == DROP_LAST) begin
                        state <= WD_IDLE;
                    end else begin
                        drop_cnt <= drop_cnt + 1'b1;
                    end
                end
                default: state <= WD_IDLE;
            endcase
        end
    end

    // Sticky timeout flag: set by a forced reset, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_sticky <= 1'b0;
        end else if (fire) begin
            tmo_sticky <= 1'b1;
        end else if (tmo_clear) begin
            tmo_sticky <= 1'b0;
        end
    end

    // Decode the outputs from the state.
    always_comb begin
        armed     = (state == WD_ARMED);
        engine_en = (state != WD_DROP);
    end

endmodule

// File: rtl/i2c_hang_watchdog.sv
// Module: i2c_hang_watchdog (top)
// Guards an I2C slave engine against holding the bus. It joins the line
// synchronizer, the condition flags, the poll prescaler and the control FSM.
// Assumes: slv_event is a one-cycle pulse in the clk domain; scl_in and
// sda_in may be asynchronous. The default TICK_DIV gives 4 ms at 125 MHz.
module i2c_hang_watchdog #(
    parameter int TICK_DIV    = 500000,
    parameter int POLL_LIMIT  = 256,
    parameter int DROP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic slv_event,
    input  logic tmo_clear,
    output logic engine_en,
    output logic wd_armed,
    output logic tmo_sticky,
    output logic start_seen,
    output logic stop_seen
);

    logic start_det;
    logic stop_det;
    logic tick;

    iwd_line_sync #(.SYNC_STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    iwd_cond_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .start_seen (start_seen),
        .stop_seen  (stop_seen)
    );

    iwd_poll_timer #(.TICK_DIV(TICK_DIV)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wd_armed),
        .restart (slv_event),
        .tick    (tick)
    );

    iwd_guard_fsm #(
        .POLL_LIMIT  (POLL_LIMIT),
        .DROP_CYCLES (DROP_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slv_event  (slv_event),
        .tick       (tick),
        .stop_seen  (stop_seen),
        .tmo_clear  (tmo_clear),
        .armed      (wd_armed),
        .engine_en  (engine_en),
        .tmo_sticky (tmo_sticky)
    );

endmodule

// File: rtl/iwd_checker.sv
// Module: iwd_checker
// Property checks on the watchdog's ports, attached to the top by bind.
// Assumes: synchronous active-low reset; DROP_CYCLES matches the top.
module iwd_checker #(
    parameter int DROP_CYCLES = 4
) (
    input logic clk,
    input logic rst_n,
    input logic slv_event,
    input logic engine_en,
    input logic wd_armed,
    input logic tmo_sticky,
    input logic start_seen,
    input logic stop_seen
);

    localparam int RUN_W = $clog2(DROP_CYCLES + 2) + 1;

    logic [RUN_W-1:0] low_run;

    // Count how many cycles engine_en has been low so far.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!engine_en) begin
            low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    // R1
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_seen && stop_seen));

    // R2
    arm_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_event && engine_en) |=> wd_armed);

    // R3
    disarm_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wd_armed) && engine_en && $past(rst_n)) |-> $past(stop_seen));

    // R5
    drop_not_too_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !engine_en |-> (low_run < RUN_W'(DROP_CYCLES)));

    // R5
    drop_full_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(engine_en) |-> (low_run == RUN_W'(DROP_CYCLES)));

    // R5
    idle_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(engine_en) |-> !wd_armed);

    // R6
    sticky_with_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(engine_en) |-> tmo_sticky);

    // R6
    sticky_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_sticky) |-> !engine_en);

endmodule

bind i2c_hang_watchdog iwd_checker #(.DROP_CYCLES(DROP_CYCLES)) u_iwd_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slv_event  (slv_event),
    .engine_en  (engine_en),
    .wd_armed   (wd_armed),
    .tmo_sticky (tmo_sticky),
    .start_seen (start_seen),
    .stop_seen  (stop_seen)
);

// File: tb/test_i2c_hang_watchdog.sv
`timescale 1ns/1ps
// Directed bench for the I2C bus-hang watchdog: one task per scenario.
module test_i2c_hang_watchdog;

    localparam int DIV  = 8;
    localparam int LIM  = 16;
    localparam int DROP = 4;
    localparam int TMO  = LIM * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic slv_event = 1'b0;
    logic tmo_clear = 1'b0;
    logic engine_en, wd_armed, tmo_sticky, start_seen, stop_seen;

    int checks = 0;
    int fails  = 0;
    int low_cnt = 0;

    always #4 clk = ~clk;

    i2c_hang_watchdog #(
        .TICK_DIV    (DIV),
        .POLL_LIMIT  (LIM),
        .DROP_CYCLES (DROP)
    ) i_i2c_hang_watchdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .slv_event  (slv_event),
        .tmo_clear  (tmo_clear),
        .engine_en  (engine_en),
        .wd_armed   (wd_armed),
        .tmo_sticky (tmo_sticky),
        .start_seen (start_seen),
        .stop_seen  (stop_seen)
    );

    // Count cycles with the enable low, sampled away from the active edge.
    always @(negedge clk) if (rst_n && !engine_en) low_cnt++;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_event();
        slv_event = 1'b1;
        @(negedge clk);
        slv_event = 1'b0;
    endtask

    task automatic bus_start();
        scl_in = 1'b1; sda_in = 1'b1; cyc(3);
        sda_in = 1'b0; cyc(5);
    endtask

    task automatic bus_stop();
        scl_in = 1'b1; sda_in = 1'b0; cyc(3);
        sda_in = 1'b1; cyc(5);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cyc(3);
        rst_n = 1'b1; cyc(1);
    endtask

    // R8: state after reset, also from the middle of an armed period.
    task automatic t_reset();
        do_reset();
        chk(engine_en, 1, "R8 en"); chk(wd_armed, 0, "R8 armed");
        chk(tmo_sticky, 0, "R8 sticky");
        chk(start_seen, 0, "R8 start"); chk(stop_seen, 0, "R8 stop");
        bus_start(); pulse_event();
        chk(wd_armed, 1, "R8 armed before reset");
        do_reset();
        chk(wd_armed, 0, "R8 armed cleared"); chk(start_seen, 0, "R8 start cleared");
    endtask

    // R1: start, stop, and SDA moving while SCL is low.
    task automatic t_conditions();
        bus_start();
        chk(start_seen, 1, "R1 start sets"); chk(stop_seen, 0, "R1 start clears stop");
        bus_stop();
        chk(stop_seen, 1, "R1 stop sets"); chk(start_seen, 0, "R1 stop clears start");
        scl_in = 1'b0; cyc(3);
        sda_in = 1'b0; cyc(4); sda_in = 1'b1; cyc(4); sda_in = 1'b0; cyc(4);
        scl_in = 1'b1; cyc(4); scl_in = 1'b0; cyc(2); sda_in = 1'b1; cyc(4);
        chk(stop_seen, 1, "R1 SCL-low data keeps stop");
        chk(start_seen, 0, "R1 SCL-low data no start");
        scl_in = 1'b1; cyc(3);
    endtask

    // R2/R3: normal transfer, armed by events, disarmed by the stop.
    task automatic t_normal();
        low_cnt = 0;
        bus_start(); pulse_event();
        chk(wd_armed, 1, "R2 event arms");
        cyc(20); pulse_event(); cyc(5);
        bus_stop();
        cyc(DIV + 2);
        chk(wd_armed, 0, "R3 stop disarms on tick");
        cyc(TMO + 20);
        chk(low_cnt, 0, "R3 no drop after stop"); chk(tmo_sticky, 0, "R3 no timeout");
    endtask

    // R4/R5/R6: stalled transfer forces a reset of exact timing and length.
    task automatic t_timeout();
        low_cnt = 0;
        bus_start(); pulse_event();
        cyc(TMO - 1);
        chk(engine_en, 1, "R4 not one cycle early"); chk(wd_armed, 1, "R4 still armed");
        cyc(1);
        chk(engine_en, 0, "R4 drop at timeout"); chk(tmo_sticky, 1, "R6 sticky set");
        pulse_event();
        cyc(DROP - 2);
        chk(engine_en, 0, "R5 still low on last drop cycle");
        cyc(1);
        chk(engine_en, 1, "R5 enable restored"); chk(wd_armed, 0, "R5 idle, event ignored");
        chk(low_cnt, DROP, "R5 drop length");
        cyc(TMO + 10);
        chk(low_cnt, DROP, "R5 no second drop");
        chk(tmo_sticky, 1, "R6 sticky holds");
        tmo_clear = 1'b1; cyc(1); tmo_clear = 1'b0;
        chk(tmo_sticky, 0, "R6 cleared");
    endtask

    // R7: event on the tick edge restarts the full timeout.
    task automatic t_collision();
        low_cnt = 0;
        bus_start(); pulse_event();
        cyc(DIV - 1);
        pulse_event();
        cyc(TMO - DIV);
        chk(engine_en, 1, "R7 tick not counted");
        cyc(DIV - 1);
        chk(engine_en, 1, "R7 one cycle before full timeout");
        cyc(1);
        chk(engine_en, 0, "R7 drop at full timeout");
        cyc(DROP + 2);
        tmo_clear = 1'b1; cyc(1); tmo_clear = 1'b0;
    endtask

    // R9: steady events keep the watchdog armed across several timeouts.
    task automatic t_keepalive();
        low_cnt = 0;
        bus_start();
        for (int i = 0; i < 5; i++) begin
            pulse_event(); cyc(TMO - 28);
        end
        chk(low_cnt, 0, "R9 no drop with steady events");
        chk(wd_armed, 1, "R9 still armed");
        bus_stop(); cyc(DIV + 2);
        chk(wd_armed, 0, "R9 stop ends it");
    endtask

    initial begin
        t_reset();
        t_conditions();
        t_normal();
        t_timeout();
        t_collision();
        t_keepalive();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule